// File: doc/BRIEF.md
# Two-Slice Cascaded Priority Encoder

This block turns a 16-line request vector into the 4-bit index of the highest-numbered active line. It is built from two identical 8-line priority encoder slices rather than one flat encoder. Each slice has an enable input and produces a binary code plus two flags. The "found" flag (GS) says the slice is enabled and saw at least one active line. The "pass" flag (EO) says the slice is enabled and saw no active line. All signals are active high and the whole path is combinational.

The upper slice looks at lines 15..8 and takes the external enable. Its pass flag enables the lower slice, which looks at lines 7..0, so the lower half is only encoded when the upper half is quiet. The upper slice's found flag becomes the code MSB. The lower code bits are the bitwise OR of both slices' codes. This works because a slice that is disabled or idle drives a code of zero. The slice width is a power-of-two parameter, and the cascade code is one bit wider than a slice code.

Top module: `pe_cascade_top`

## Requirements
- R1: Among several active lines the highest-numbered one is encoded. Line 15 has the highest priority and line 0 the lowest, and `code_o` gives its index as an unsigned binary number.
- R2: With `en_i` = 0, `code_o`, `gs_o` and `eo_o` are all 0 for every value of `data_i`.
- R3: `gs_o` is 1 exactly when `en_i` is 1 and at least one bit of `data_i` is 1.
- R4: `eo_o` is 1 exactly when `en_i` is 1 and every bit of `data_i` is 0. `gs_o` and `eo_o` are never both 1.
- R5: When any of lines 15..8 is active, lines 7..0 have no effect on `code_o` (bit 3 is 1 and the lower three bits come from the upper half).
- R6: `code_o[3]` is 1 exactly when the block is enabled and one of lines 15..8 is active.
- R7: Single-line cases: line 15 alone gives `1111`, line 8 alone gives `1000` and line 1 alone gives `0001`.
- R8: Enabled with no line active, the outputs are `code_o` = `0000`, `gs_o` = 0 and `eo_o` = 1.
- R9: With the default slice width of 8, `data_i` is 16 bits and `code_o` is 4 bits (log2 of the slice width, plus one).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en_i | input | 1 | Enable for the whole encoder; it feeds the upper slice |
| data_i | input | 16 | Request lines; bit 15 has the highest priority |
| code_o | output | 4 | Index of the highest active line, 0 when nothing is found |
| gs_o | output | 1 | Enabled and at least one line active |
| eo_o | output | 1 | Enabled and no line active |

## Verification
The block holds no state, so every result is due in the same cycle as the input change that causes it. No register lies between the inputs and the outputs. The bench changes the inputs just after a rising edge and reads the outputs at the following falling edge, half a period later, when the logic has settled. Each of the 65536 request patterns is applied once with the enable low and once with it high. Each result is compared with a reference that scans downward from line 15.

// File: rtl/pe_pkg.sv
package pe_pkg;

    // Default number of request lines per slice.
    localparam int unsigned DEF_SLICE_W = 8;

    // True when the argument is a non-zero power of two.
    function automatic bit is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/pe_lead_find.sv
module pe_lead_find #(
    parameter int unsigned N  = pe_pkg::DEF_SLICE_W,
    localparam int unsigned CW = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    output logic [CW-1:0] idx_o,
    output logic          any_o
);

    logic [CW-1:0] idx_d;

    // Ascending scan: a later (higher) set bit overwrites an earlier one.
    always_comb begin
        idx_d = '0;
        for (int i = 0; i < N; i++) begin
            if (vec_i[i]) begin
                idx_d = CW'(i);
            end
        end
    end

    assign idx_o = idx_d;
    assign any_o = |vec_i;

endmodule

// File: rtl/pe_slice.sv
module pe_slice #(
    parameter int unsigned N  = pe_pkg::DEF_SLICE_W,
    localparam int unsigned CW = $clog2(N)
) (
    input  logic          en_i,
    input  logic [N-1:0]  vec_i,
    output logic [CW-1:0] code_o,
    output logic          gs_o,
    output logic          eo_o
);

    if (!pe_pkg::is_pow2(N) || N < 2) begin : g_bad_width
        $error("pe_slice: N must be a power of two of at least 2");
    end

    typedef struct packed {
        logic [CW-1:0] code;
        logic          gs;
        logic          eo;
    } slice_out_t;

    logic [CW-1:0] raw_idx;
    logic          raw_any;
    slice_out_t    out_d;

    pe_lead_find #(.N(N)) u_find (
        .vec_i (vec_i),
        .idx_o (raw_idx),
        .any_o (raw_any)
    );

    always_comb begin
        out_d      = '0;
        out_d.gs   = en_i & raw_any;
        out_d.eo   = en_i & ~raw_any;
        out_d.code = out_d.gs ? raw_idx : '0;
    end

    assign code_o = out_d.code;
    assign gs_o   = out_d.gs;
    assign eo_o   = out_d.eo;

    always_comb begin
        if (!$isunknown({en_i, vec_i})) begin
            // R2
            slice_off_quiet_chk: assert (en_i || (code_o == '0 && !gs_o && !eo_o))
                else $error("slice drives outputs while disabled");
            // R4
            slice_flags_excl_chk: assert (!(gs_o && eo_o))
                else $error("slice found and pass flags both set");
            // R1
            slice_top_bit_chk: assert (!gs_o || ((vec_i >> code_o) == N'(1)))
                else $error("slice code is not the highest active line");
            // R8
            slice_idle_code_chk: assert (gs_o || code_o == '0)
                else $error("slice code non-zero without a find");
        end
    end

endmodule

// File: rtl/pe_merge.sv
module pe_merge #(
    parameter int unsigned CW = 3
) (
    input  logic [CW-1:0] hi_code_i,
    input  logic [CW-1:0] lo_code_i,
    input  logic          hi_gs_i,
    output logic [CW:0]   code_o
);

    for (genvar b = 0; b < CW; b++) begin : g_or
        assign code_o[b] = hi_code_i[b] | lo_code_i[b];
    end
    assign code_o[CW] = hi_gs_i;

endmodule

// File: rtl/pe_cascade_top.sv
module pe_cascade_top #(
    parameter int unsigned SLICE_W = pe_pkg::DEF_SLICE_W,
    localparam int unsigned CW     = $clog2(SLICE_W),
    localparam int unsigned DW     = 2 * SLICE_W
) (
    input  logic          en_i,
    input  logic [DW-1:0] data_i,
    output logic [CW:0]   code_o,
    output logic          gs_o,
    output logic          eo_o
);

    logic [CW-1:0] hi_code, lo_code;
    logic          hi_gs, hi_eo, lo_gs, lo_eo;

    // Upper half sees the external enable; its pass flag enables the lower half.
    pe_slice #(.N(SLICE_W)) u_hi (
        .en_i   (en_i),
        .vec_i  (data_i[DW-1:SLICE_W]),
        .code_o (hi_code),
        .gs_o   (hi_gs),
        .eo_o   (hi_eo)
    );

    pe_slice #(.N(SLICE_W)) u_lo (
        .en_i   (hi_eo),
        .vec_i  (data_i[SLICE_W-1:0]),
        .code_o (lo_code),
        .gs_o   (lo_gs),
        .eo_o   (lo_eo)
    );

    pe_merge #(.CW(CW)) u_merge (
        .hi_code_i (hi_code),
        .lo_code_i (lo_code),
        .hi_gs_i   (hi_gs),
        .code_o    (code_o)
    );

    assign gs_o = hi_gs | lo_gs;
    assign eo_o = lo_eo;

    always_comb begin
        if (!$isunknown({en_i, data_i})) begin
            // R5
            lo_masked_chk: assert (!(hi_gs && lo_gs))
                else $error("both slices report a find");
            // R4
            top_flags_excl_chk: assert (!(gs_o && eo_o))
                else $error("cascade found and pass flags both set");
            // R6
            msb_upper_chk: assert (code_o[CW] == (en_i && |data_i[DW-1:SLICE_W]))
                else $error("code MSB disagrees with upper half activity");
            // R2
            top_off_quiet_chk: assert (en_i || (code_o == '0 && !gs_o && !eo_o))
                else $error("cascade drives outputs while disabled");
        end
    end

endmodule

// File: tb/tb_pe_cascade_top.sv
module tb_pe_cascade_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en_i;
    logic [15:0] data_i;
    logic [3:0]  code_o;
    logic        gs_o, eo_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pe_cascade_top dut (
        .en_i   (en_i),
        .data_i (data_i),
        .code_o (code_o),
        .gs_o   (gs_o),
        .eo_o   (eo_o)
    );

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: data=%h en=%b actual code/gs/eo=%b expected=%b",
                     req, data_i, en_i, act, exp);
        end
    endtask

    // Reference: scan from line 15 downward for the first active line.
    function automatic logic [5:0] ref_model(input logic en, input logic [15:0] d);
        logic [3:0] c = 4'd0;
        logic found = 1'b0;
        for (int i = 15; i >= 0; i--) begin
            if (!found && d[i]) begin
                c = 4'(i);
                found = 1'b1;
            end
        end
        if (!en) return 6'b0;
        return {c, found, ~found};
    endfunction

    task automatic drive(input logic en, input logic [15:0] d);
        @(posedge clk);
        #0.5;
        en_i   = en;
        data_i = d;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        drive(1'b0, 16'h0000);
        check("R2 reset", {code_o, gs_o, eo_o}, 6'b0);
        check("R9 width", 6'($bits(code_o)), 6'd4);
        check("R9 width", 6'($bits(data_i)), 6'd16);
    endtask

    task automatic t_corners();
        drive(1'b1, 16'h8000); check("R7 line15", {code_o, gs_o, eo_o}, {4'b1111, 2'b10});
        drive(1'b1, 16'h0100); check("R7 line8",  {code_o, gs_o, eo_o}, {4'b1000, 2'b10});
        drive(1'b1, 16'h0002); check("R7 line1",  {code_o, gs_o, eo_o}, {4'b0001, 2'b10});
        drive(1'b1, 16'h0000); check("R8 idle",   {code_o, gs_o, eo_o}, {4'b0000, 2'b01});
        drive(1'b1, 16'h0280); check("R5 mask",   {code_o, gs_o, eo_o}, {4'b1001, 2'b10});
        drive(1'b1, 16'h00FF); check("R1 multi",  {code_o, gs_o, eo_o}, {4'b0111, 2'b10});
        drive(1'b0, 16'hFFFF); check("R2 off",    {code_o, gs_o, eo_o}, 6'b0);
    endtask

    task automatic t_sweep(input logic en);
        for (int v = 0; v < 65536; v++) begin
            drive(en, 16'(v));
            if (en) check("R1 R3 R4 R6 sweep", {code_o, gs_o, eo_o}, ref_model(en, 16'(v)));
            else    check("R2 sweep",          {code_o, gs_o, eo_o}, 6'b0);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual cycles=%0d expected below 190000", cycles);
            finish_run();
        end
    end

    initial begin
        en_i   = 1'b0;
        data_i = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_corners();
        t_sweep(1'b1);
        t_sweep(1'b0);
        done = 1'b1;
        finish_run();
    end

endmodule